// File: doc/BRIEF.md
# Opcode Prefix Decoder with Compatibility Mode

This block is the first decode stage of an 8-bit processor front end. It watches the opcode byte stream one byte per strobe and sorts each instruction into an instruction group before operand fetch and execution take over. A mode input picks between the extended instruction set and the older compatible set. In extended mode, four byte values act as prefixes: they open a new instruction group and do not end the instruction. In compatible mode, the same four values are ordinary opcodes. Those opcodes are redundant unconditional jump or call encodings, and the block flags them as aliases.

A prefix byte is not reported as an instruction. It moves an internal group register forward and adds a fixed penalty of clock cycles to a running counter. The first byte that cannot act as a prefix completes the instruction. One cycle after that byte is accepted, the block raises a one-cycle completion pulse. At the same time it presents the group, the final opcode byte, the accumulated penalty, the alias flag, and a no-op flag for loads of a register into itself. These outputs hold their values until the next instruction completes.

Top module: `op_prefix_decoder`

## Requirements
- R1: After reset, done_o=0, class_o=0 (plain), opcode_o=00h, extra_cyc_o=0, alias_o=0, nop_o=0.
- R2: In extended mode (ext_mode_i=1), CBh opens the bit group. The next byte completes with class_o=1 and extra_cyc_o=4, even if that byte is CBh itself.
- R3: In extended mode, DDh opens index group X (class 2), FDh opens index group Y (class 3), and EDh opens the extended group (class 4). Each completes on the next non-prefix byte with extra_cyc_o=4. A non-prefix byte with no pending prefix completes as class 0 with extra_cyc_o=0.
- R4: In compatible mode (ext_mode_i=0), every byte completes at once as class 0 with extra_cyc_o=0. alias_o=1 exactly when the byte is CBh, DDh, EDh or FDh (redundant jump/call encodings); C3h and other bytes give alias_o=0. In extended mode alias_o is always 0.
- R5: In extended mode, CBh after DDh gives class 5 and CBh after FDh gives class 6. The decoder then waits for one further byte, which completes with extra_cyc_o=8.
- R6: A DDh or FDh that follows a pending DDh or FDh replaces the earlier index group. Each prefix adds 4 to extra_cyc_o, so DDh FDh DDh 21h gives class 2 with extra 12.
- R7: done_o goes high for one cycle, in the cycle after the final byte is accepted. A prefix byte produces no pulse.
- R8: nop_o=1 on completion exactly when the final byte is 40h, 49h, 52h, 5Bh, 64h, 6Dh or 7Fh and the class is 0. 76h and 41h give 0, and a pending prefix also gives 0.
- R9: While byte_valid_i is low, class_o, opcode_o, extra_cyc_o, alias_o and nop_o keep their last values.
- R10: Once the extended group (EDh) or a bit group is open, the next byte completes regardless of its value. EDh after DDh switches to the extended group, and its penalty still accumulates (DDh EDh 44h gives class 4, extra 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Fetched byte strobe |
| byte_i | input | 8 | Fetched opcode byte |
| ext_mode_i | input | 1 | 1 = extended set, 0 = compatible set |
| done_o | output | 1 | One-cycle instruction-complete pulse |
| class_o | output | 3 | Instruction group of the completed instruction |
| opcode_o | output | 8 | Final opcode byte |
| extra_cyc_o | output | 6 | Prefix penalty in clock cycles |
| alias_o | output | 1 | Redundant jump/call encoding (compatible mode) |
| nop_o | output | 1 | Register-to-itself load, flags untouched |

## Verification
If the group register is wrong, the error shows up at the very next completion pulse. A lost prefix gives the wrong class_o and an extra_cyc_o that is short by 4. A stuck prefix state swallows a byte, so the expected pulse is missing one cycle after that byte. A counter that fails to clear shows up as an inflated penalty on the following plain instruction. In compatible mode, a prefix state that leaks in suppresses a pulse right away.

// File: rtl/op_pfx_pkg.sv
package op_pfx_pkg;
  typedef enum logic [2:0] {
    GRP_PLAIN     = 3'd0,
    GRP_BIT       = 3'd1,
    GRP_IDX_X     = 3'd2,
    GRP_IDX_Y     = 3'd3,
    GRP_EXT       = 3'd4,
    GRP_IDX_X_BIT = 3'd5,
    GRP_IDX_Y_BIT = 3'd6
  } grp_e;

  localparam logic [7:0] BYTE_BIT_PFX = 8'hCB;
  localparam logic [7:0] BYTE_X_PFX   = 8'hDD;
  localparam logic [7:0] BYTE_EXT_PFX = 8'hED;
  localparam logic [7:0] BYTE_Y_PFX   = 8'hFD;
endpackage

// File: rtl/op_pfx_byte_class.sv
module op_pfx_byte_class
  import op_pfx_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       bit_pfx_o,
  output logic       x_pfx_o,
  output logic       y_pfx_o,
  output logic       ext_pfx_o,
  output logic       self_ld_o
);
  assign bit_pfx_o = (byte_i == BYTE_BIT_PFX);
  assign x_pfx_o   = (byte_i == BYTE_X_PFX);
  assign y_pfx_o   = (byte_i == BYTE_Y_PFX);
  assign ext_pfx_o = (byte_i == BYTE_EXT_PFX);
  // 01 ddd sss with ddd==sss; 110 is halt, not a load
  assign self_ld_o = (byte_i[7:6] == 2'b01) && (byte_i[5:3] == byte_i[2:0]) &&
                     (byte_i[2:0] != 3'b110);
endmodule

// File: rtl/op_pfx_fsm.sv
module op_pfx_fsm
  import op_pfx_pkg::*;
#(
  parameter int PFX_CYCLES = 4,
  parameter int CNT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic             ext_mode_i,
  input  logic             bit_pfx_i,
  input  logic             x_pfx_i,
  input  logic             y_pfx_i,
  input  logic             ext_pfx_i,
  output logic             final_o,
  output grp_e             fin_grp_o,
  output logic [CNT_W-1:0] fin_cnt_o
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int CNT_SAT = CNT_MAX - (CNT_MAX % PFX_CYCLES);

  grp_e             grp_q, grp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_w, is_pfx;

  assign open_w = (grp_q == GRP_PLAIN) || (grp_q == GRP_IDX_X) || (grp_q == GRP_IDX_Y);
  assign is_pfx = ext_mode_i && open_w && (bit_pfx_i || x_pfx_i || y_pfx_i || ext_pfx_i);

  assign final_o   = byte_valid_i && !is_pfx;
  assign fin_grp_o = ext_mode_i ? grp_q : GRP_PLAIN;
  assign fin_cnt_o = cnt_q;

  always_comb begin
    grp_d = grp_q;
    cnt_d = cnt_q;
    if (byte_valid_i) begin
      if (is_pfx) begin
        if (x_pfx_i)        grp_d = GRP_IDX_X;
        else if (y_pfx_i)   grp_d = GRP_IDX_Y;
        else if (ext_pfx_i) grp_d = GRP_EXT;
        else if (grp_q == GRP_IDX_X) grp_d = GRP_IDX_X_BIT;
        else if (grp_q == GRP_IDX_Y) grp_d = GRP_IDX_Y_BIT;
        else                grp_d = GRP_BIT;
        if (int'(cnt_q) + PFX_CYCLES <= CNT_SAT) cnt_d = cnt_q + CNT_W'(PFX_CYCLES);
      end else begin
        grp_d = GRP_PLAIN;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= GRP_PLAIN;
      cnt_q <= '0;
    end else begin
      grp_q <= grp_d;
      cnt_q <= cnt_d;
    end
  end

  assert_x_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && ext_mode_i && grp_q == GRP_PLAIN && x_pfx_i) |=> (grp_q == GRP_IDX_X));

  assert_closed_grp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && (grp_q == GRP_EXT || grp_q == GRP_BIT)) |=> (grp_q == GRP_PLAIN && cnt_q == '0));

  assert_idx_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && ext_mode_i && grp_q == GRP_IDX_Y && bit_pfx_i) |=> (grp_q == GRP_IDX_Y_BIT));
endmodule

// File: rtl/op_prefix_decoder.sv
module op_prefix_decoder
  import op_pfx_pkg::*;
#(
  parameter int PFX_CYCLES = 4,
  parameter int CNT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             ext_mode_i,
  output logic             done_o,
  output logic [2:0]       class_o,
  output logic [7:0]       opcode_o,
  output logic [CNT_W-1:0] extra_cyc_o,
  output logic             alias_o,
  output logic             nop_o
);
  logic bit_pfx, x_pfx, y_pfx, ext_pfx, self_ld;
  logic fin;
  grp_e fin_grp;
  logic [CNT_W-1:0] fin_cnt;

  op_pfx_byte_class u_cls (
    .byte_i    (byte_i),
    .bit_pfx_o (bit_pfx),
    .x_pfx_o   (x_pfx),
    .y_pfx_o   (y_pfx),
    .ext_pfx_o (ext_pfx),
    .self_ld_o (self_ld)
  );

  op_pfx_fsm #(.PFX_CYCLES(PFX_CYCLES), .CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .ext_mode_i   (ext_mode_i),
    .bit_pfx_i    (bit_pfx),
    .x_pfx_i      (x_pfx),
    .y_pfx_i      (y_pfx),
    .ext_pfx_i    (ext_pfx),
    .final_o      (fin),
    .fin_grp_o    (fin_grp),
    .fin_cnt_o    (fin_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      class_o     <= GRP_PLAIN;
      opcode_o    <= '0;
      extra_cyc_o <= '0;
      alias_o     <= 1'b0;
      nop_o       <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        class_o     <= fin_grp;
        opcode_o    <= byte_i;
        extra_cyc_o <= fin_cnt;
        // compatible mode: prefix values are redundant jump/call encodings
        alias_o     <= !ext_mode_i && (bit_pfx || x_pfx || y_pfx || ext_pfx);
        nop_o       <= self_ld && (fin_grp == GRP_PLAIN);
      end
    end
  end

  assert_done_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(byte_valid_i));

  assert_nop_plain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_o |-> (class_o == GRP_PLAIN));

  assert_alias_plain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && alias_o) |-> (class_o == GRP_PLAIN && extra_cyc_o == '0));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> ($stable(opcode_o) && $stable(class_o) && !done_o));
endmodule

// File: tb/op_prefix_decoder_tb.sv
`timescale 1ns/1ps
module op_prefix_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] bt = '0;
  logic       mode = 1'b1;
  logic       done, alias_f, nop_f;
  logic [2:0] cls;
  logic [7:0] opc;
  logic [5:0] extra;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  op_prefix_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(vld), .byte_i(bt), .ext_mode_i(mode),
    .done_o(done), .class_o(cls), .opcode_o(opc), .extra_cyc_o(extra),
    .alias_o(alias_f), .nop_o(nop_f)
  );

  // {mode, byte, done, class, extra, alias, nop, req}
  localparam int NV = 36;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'hCB, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'h47, 1'b1, 3'd1, 6'd4,  1'b0, 1'b0, 4'd2},
    {1'b1, 8'hDD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'h21, 1'b1, 3'd2, 6'd4,  1'b0, 1'b0, 4'd3},
    {1'b1, 8'hFD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'hE5, 1'b1, 3'd3, 6'd4,  1'b0, 1'b0, 4'd3},
    {1'b1, 8'hED, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'hB0, 1'b1, 3'd4, 6'd4,  1'b0, 1'b0, 4'd3},
    {1'b1, 8'h3E, 1'b1, 3'd0, 6'd0,  1'b0, 1'b0, 4'd3},
    {1'b0, 8'hCB, 1'b1, 3'd0, 6'd0,  1'b1, 1'b0, 4'd4},
    {1'b0, 8'hDD, 1'b1, 3'd0, 6'd0,  1'b1, 1'b0, 4'd4},
    {1'b0, 8'hED, 1'b1, 3'd0, 6'd0,  1'b1, 1'b0, 4'd4},
    {1'b0, 8'hFD, 1'b1, 3'd0, 6'd0,  1'b1, 1'b0, 4'd4},
    {1'b0, 8'hC3, 1'b1, 3'd0, 6'd0,  1'b0, 1'b0, 4'd4},
    {1'b1, 8'hDD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'hCB, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd5},
    {1'b1, 8'h06, 1'b1, 3'd5, 6'd8,  1'b0, 1'b0, 4'd5},
    {1'b1, 8'hFD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'hCB, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd5},
    {1'b1, 8'h46, 1'b1, 3'd6, 6'd8,  1'b0, 1'b0, 4'd5},
    {1'b1, 8'hDD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd6},
    {1'b1, 8'hFD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd6},
    {1'b1, 8'hDD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd6},
    {1'b1, 8'h21, 1'b1, 3'd2, 6'd12, 1'b0, 1'b0, 4'd6},
    {1'b1, 8'h7F, 1'b1, 3'd0, 6'd0,  1'b0, 1'b1, 4'd8},
    {1'b1, 8'h76, 1'b1, 3'd0, 6'd0,  1'b0, 1'b0, 4'd8},
    {1'b0, 8'h49, 1'b1, 3'd0, 6'd0,  1'b0, 1'b1, 4'd8},
    {1'b1, 8'h41, 1'b1, 3'd0, 6'd0,  1'b0, 1'b0, 4'd8},
    {1'b1, 8'hDD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'h7F, 1'b1, 3'd2, 6'd4,  1'b0, 1'b0, 4'd8},
    {1'b1, 8'hED, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'hDD, 1'b1, 3'd4, 6'd4,  1'b0, 1'b0, 4'd10},
    {1'b1, 8'hDD, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7},
    {1'b1, 8'hED, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd10},
    {1'b1, 8'h44, 1'b1, 3'd4, 6'd8,  1'b0, 1'b0, 4'd10},
    {1'b1, 8'hCB, 1'b0, 3'd0, 6'd0,  1'b0, 1'b0, 4'd7}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic send(input logic m, input logic [7:0] b);
    mode = m; bt = b; vld = 1'b1;
    @(posedge clk); #1;
    vld = 1'b0;
  endtask

  task automatic check_all(input string req, input logic e_done, input logic [2:0] e_cls,
                           input logic [7:0] e_opc, input logic [5:0] e_ext,
                           input logic e_al, input logic e_nop);
    checks++;
    if ({done, cls, opc, extra, alias_f, nop_f} !== {e_done, e_cls, e_opc, e_ext, e_al, e_nop}) begin
      errors++;
      $display("FAIL %s: got done=%0b cls=%0d opc=%h ext=%0d alias=%0b nop=%0b exp done=%0b cls=%0d opc=%h ext=%0d alias=%0b nop=%0b",
               req, done, cls, opc, extra, alias_f, nop_f, e_done, e_cls, e_opc, e_ext, e_al, e_nop);
    end
  endtask

  task automatic check_done(input string req, input logic e_done);
    checks++;
    if (done !== e_done) begin
      errors++;
      $display("FAIL %s: done got %0b exp %0b", req, done, e_done);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1", 1'b0, 3'd0, 8'h00, 6'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][24], VEC[i][23:16]);
      if (VEC[i][15])
        check_all(req_name(VEC[i][3:0]), 1'b1, VEC[i][14:12], VEC[i][23:16],
                  VEC[i][11:6], VEC[i][5], VEC[i][4]);
      else
        check_done(req_name(VEC[i][3:0]), 1'b0);
    end
    // last vector left a bit prefix pending: CB CB -> bit group, opcode CB (R2)
    send(1'b1, 8'hCB);
    check_all("R2", 1'b1, 3'd1, 8'hCB, 6'd4, 1'b0, 1'b0);

    // R7: pulse lasts one cycle; R9: outputs hold while idle
    send(1'b1, 8'h52);
    check_all("R8", 1'b1, 3'd0, 8'h52, 6'd0, 1'b0, 1'b1);
    @(posedge clk); #1;
    check_done("R7", 1'b0);
    bt = 8'hDD;
    repeat (3) @(posedge clk); #1;
    check_all("R9", 1'b0, 3'd0, 8'h52, 6'd0, 1'b0, 1'b1);

    // reset mid-prefix clears pending group and penalty (R1)
    send(1'b1, 8'hFD);
    rst_n = 1'b0; #3; rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1", 1'b0, 3'd0, 8'h00, 6'd0, 1'b0, 1'b0);
    send(1'b1, 8'h21);
    check_all("R3", 1'b1, 3'd0, 8'h21, 6'd0, 1'b0, 1'b0);

    // back-to-back completions keep done high each cycle (R7)
    send(1'b0, 8'h6D);
    check_all("R8", 1'b1, 3'd0, 8'h6D, 6'd0, 1'b0, 1'b1);
    send(1'b0, 8'hED);
    check_all("R4", 1'b1, 3'd0, 8'hED, 6'd0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check_done("R7", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule